// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps a 24-hour time of day in four cascaded two-digit BCD counters: hundredths of a second, seconds, minutes and hours. It is clocked by the system clock and advances on a single-cycle enable that an external prescaler raises once every 10 ms. Every counter counts directly in BCD, so the packed 32-bit time word can feed a digit multiplexer and segment decoder without any binary-to-decimal conversion.

Three level-sensitive adjustment inputs set the time. Each of them passes through a two-stage synchronizer before it takes effect. The clear input holds the seconds and hundredths at zero while it is high. The minute-step and hour-step inputs advance their counter once on every one-second strobe while they are held. The one-second strobe comes out as a port, and a companion LED output toggles on it so that the seconds can be seen running.

Top module: `tod_chain`

## Requirements
- R1: On each clock edge where `tick_i` is high, the hundredths counter advances by one. On edges where `tick_i` is low and no clear is in force, the time word does not change.
- R2: Each counter holds a BCD units digit and a BCD tens digit. When the units digit is 9, the next step makes it 0 and adds one to the tens digit. The hundredths wrap 99→00, and the seconds and minutes wrap 59→00.
- R3: A counter at its last value (99 or 59) passes a carry, and the next counter steps on the same clock edge. For example, 00:00:59.99 becomes 00:01:00.00 in one tick.
- R4: The hours count 00 to 23. The tick that follows 23:59:59.99 gives 00:00:00.00.
- R5: `time_bcd_o` packs hours in [31:24], minutes in [23:16], seconds in [15:8] and hundredths in [7:0]. Within each byte, the tens digit is in the upper nibble and the units digit is in the lower nibble.
- R6: Synchronous active-high `rst` makes the time word zero and `led_o` low, and clears the synchronizers.
- R7: While the synchronized clear is high, the hundredths and seconds read 00 whether or not ticks arrive. No one-second strobe is produced, and the minutes and hours do not change.
- R8: While the synchronized minute-step is high, the minutes advance by one on each one-second strobe and wrap 59→00. Such a step never carries into the hours.
- R9: While the synchronized hour-step is high, the hours advance by one on each one-second strobe and wrap 23→00.
- R10: `sec_strobe_o` is high for exactly the cycle in which `tick_i` is high, the hundredths read 99 and no clear is in force. `led_o` inverts on the edge that ends that cycle.
- R11: An adjustment input driven high takes effect on the third rising clock edge after it changes. The two edges before that leave the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Single-cycle 10 ms advance enable |
| clr_hold_i | input | 1 | Hold seconds and hundredths at zero (asynchronous level) |
| min_set_i | input | 1 | Step minutes once per second while high (asynchronous level) |
| hr_set_i | input | 1 | Step hours once per second while high (asynchronous level) |
| time_bcd_o | output | 32 | Packed BCD time {hh, mm, ss, cc} |
| sec_strobe_o | output | 1 | One-cycle one-second strobe |
| led_o | output | 1 | Toggles on every one-second strobe |

## Verification
Three tick patterns drive the chain: a tick on every cycle, a tick on every third cycle, and long idle gaps. Together they separate counting on the enable from counting on the clock, and the continuous run sweeps every hundredths value and every seconds and minutes carry. Each adjustment input is held across many strobes, and the expected time is checked against an arithmetic model. This shows whether set-induced steps are kept out of the hour carry and whether clear holds only the low two counters. A forced approach to 23:59:59.99 exposes the midnight rollover. The timing of the clear taking effect pins down the two-stage synchronizer delay.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W = 4;
    localparam int PAIR_W  = 2 * DIGIT_W;
    localparam int NUM_PAIRS = 4;
    localparam int TIME_W  = NUM_PAIRS * PAIR_W;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } pair_t;
endpackage

// File: rtl/tod_sync.sv
module tod_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_o = st_q.stable;

    // R11: the output repeats the input seen two edges earlier
    a_r11_two_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ##1 (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/tod_bcd_pair.sv
module tod_bcd_pair
    import tod_pkg::*;
#(
    parameter int TENS_LAST  = 9,
    parameter int UNITS_LAST = 9
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step_i,
    input  logic  clr_i,
    input  logic  carry_gate_i,
    output pair_t value_o,
    output logic  carry_o
);
    localparam bcd_t TL   = bcd_t'(TENS_LAST);
    localparam bcd_t UL   = bcd_t'(UNITS_LAST);
    localparam bcd_t NINE = bcd_t'(9);

    pair_t st_d, st_q;
    logic  at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.tens == TL) && (st_q.units == UL);
        carry_o = step_i && at_last && carry_gate_i && !clr_i;
        if (clr_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (at_last) begin
                st_d = '0;
            end else if (st_q.units == NINE) begin
                st_d.units = '0;
                st_d.tens  = st_q.tens + bcd_t'(1);
            end else begin
                st_d.units = st_q.units + bcd_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign value_o = st_q;

    // R2: units digit stays a decimal digit
    a_r2_units_decimal: assert property (@(posedge clk) disable iff (rst)
        value_o.units <= NINE);
    // R2: tens digit never passes its last value
    a_r2_tens_bound: assert property (@(posedge clk) disable iff (rst)
        value_o.tens <= TL);
    // R4: a step at the last value returns to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clr_i && value_o.tens == TL && value_o.units == UL) |=> (value_o == '0));
    // R7: clear forces zero on the next edge
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (value_o == '0));
    // R1: no step and no clear leaves the value alone
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !clr_i) |=> $stable(value_o));
endmodule

// File: rtl/tod_chain.sv
module tod_chain
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              clr_hold_i,
    input  logic              min_set_i,
    input  logic              hr_set_i,
    output logic [TIME_W-1:0] time_bcd_o,
    output logic              sec_strobe_o,
    output logic              led_o
);
    localparam int ADJ_W = 3;
    localparam int ADJ_CLR = 0;
    localparam int ADJ_MIN = 1;
    localparam int ADJ_HR  = 2;

    typedef struct packed {
        logic led;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ADJ_W-1:0] adj_s;
    pair_t cc_v, ss_v, mm_v, hh_v;
    logic  cc_carry, ss_carry, mm_carry, hh_carry;
    logic  mm_step, hh_step;

    tod_sync #(.WIDTH(ADJ_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({hr_set_i, min_set_i, clr_hold_i}),
        .sync_o  (adj_s)
    );

    tod_bcd_pair #(.TENS_LAST(9), .UNITS_LAST(9)) u_cc (
        .clk(clk), .rst(rst), .step_i(tick_i), .clr_i(adj_s[ADJ_CLR]),
        .carry_gate_i(1'b1), .value_o(cc_v), .carry_o(cc_carry)
    );

    tod_bcd_pair #(.TENS_LAST(5), .UNITS_LAST(9)) u_ss (
        .clk(clk), .rst(rst), .step_i(cc_carry), .clr_i(adj_s[ADJ_CLR]),
        .carry_gate_i(1'b1), .value_o(ss_v), .carry_o(ss_carry)
    );

    tod_bcd_pair #(.TENS_LAST(5), .UNITS_LAST(9)) u_mm (
        .clk(clk), .rst(rst), .step_i(mm_step), .clr_i(1'b0),
        .carry_gate_i(ss_carry), .value_o(mm_v), .carry_o(mm_carry)
    );

    tod_bcd_pair #(.TENS_LAST(2), .UNITS_LAST(3)) u_hh (
        .clk(clk), .rst(rst), .step_i(hh_step), .clr_i(1'b0),
        .carry_gate_i(mm_carry), .value_o(hh_v), .carry_o(hh_carry)
    );

    always_comb begin
        mm_step  = ss_carry || (adj_s[ADJ_MIN] && cc_carry);
        hh_step  = mm_carry || (adj_s[ADJ_HR] && cc_carry);
        st_d     = st_q;
        st_d.led = st_q.led ^ cc_carry;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign time_bcd_o   = {hh_v, mm_v, ss_v, cc_v};
    assign sec_strobe_o = cc_carry;
    assign led_o        = st_q.led;

    // R10: strobe never lasts two cycles
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
        sec_strobe_o |=> !sec_strobe_o);
    // R10: LED inverts after a strobe
    a_r10_led_toggle: assert property (@(posedge clk) disable iff (rst)
        sec_strobe_o |=> (led_o != $past(led_o)));
    // R10: LED holds without a strobe
    a_r10_led_hold: assert property (@(posedge clk) disable iff (rst)
        !sec_strobe_o |=> $stable(led_o));
    // R8: hours can only move on a one-second strobe
    a_r8_hours_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !sec_strobe_o |=> $stable(time_bcd_o[31:24]));
    // R4: the day carry leaves the whole word at midnight
    a_r4_midnight: assert property (@(posedge clk) disable iff (rst)
        hh_carry |=> (time_bcd_o == '0));
endmodule

// File: tb/tod_chain_test.sv
`timescale 1ns/1ps
module tod_chain_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        clr_hold_i = 1'b0;
    logic        min_set_i = 1'b0;
    logic        hr_set_i = 1'b0;
    logic [31:0] time_bcd_o;
    logic        sec_strobe_o;
    logic        led_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cc = 0, m_ss = 0, m_mm = 0, m_hh = 0;
    bit m_led = 1'b0;
    bit m_clr = 1'b0, m_mset = 1'b0, m_hset = 1'b0;

    always #10 clk = ~clk;

    tod_chain uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .clr_hold_i(clr_hold_i),
        .min_set_i(min_set_i), .hr_set_i(hr_set_i),
        .time_bcd_o(time_bcd_o), .sec_strobe_o(sec_strobe_o), .led_o(led_o)
    );

    function automatic logic [7:0] bcd2(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [31:0] exp_word();
        return {bcd2(m_hh), bcd2(m_mm), bcd2(m_ss), bcd2(m_cc)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock cycle with the given tick level; model follows the requirements
    task automatic cyc(bit t, string req);
        bit c0, c1, c2;
        @(negedge clk);
        tick_i = t;
        #1;
        c0 = t && !m_clr && (m_cc == 99);
        c1 = c0 && (m_ss == 59);
        c2 = c1 && (m_mm == 59);
        chk({req, "/R10 strobe"}, {31'd0, sec_strobe_o}, {31'd0, c0});
        if (m_clr) begin
            m_cc = 0;
            m_ss = 0;
        end else if (t) begin
            m_cc = (m_cc + 1) % 100;
            if (c0) m_ss = (m_ss + 1) % 60;
        end
        if (c1 || (m_mset && c0)) m_mm = (m_mm + 1) % 60;
        if (c2 || (m_hset && c0)) m_hh = (m_hh + 1) % 24;
        if (c0) m_led = !m_led;
        @(posedge clk);
        #1;
        chk(req, time_bcd_o, exp_word());
        chk({req, "/R10 led"}, {31'd0, led_o}, {31'd0, m_led});
    endtask

    // drive new adjustment levels; R11: two unchanged edges, effect on the third
    task automatic set_adj(bit c, bit ms, bit hs);
        @(negedge clk);
        tick_i = 1'b0;
        clr_hold_i = c;
        min_set_i = ms;
        hr_set_i = hs;
        @(posedge clk);
        #1;
        chk("R11 edge1", time_bcd_o, exp_word());
        cyc(1'b0, "R11 edge2");
        m_clr = c;
        m_mset = ms;
        m_hset = hs;
        cyc(1'b0, "R11 edge3");
    endtask

    task automatic do_reset(string req);
        @(negedge clk);
        rst = 1'b1;
        tick_i = 1'b0;
        clr_hold_i = 1'b0;
        min_set_i = 1'b0;
        hr_set_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_cc = 0; m_ss = 0; m_mm = 0; m_hh = 0;
        m_led = 1'b0; m_clr = 1'b0; m_mset = 1'b0; m_hset = 1'b0;
        chk({req, " time"}, time_bcd_o, 32'h0);
        chk({req, " led"}, {31'd0, led_o}, 32'h0);
        chk({req, " strobe"}, {31'd0, sec_strobe_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int guard;
        do_reset("R6");

        // R1: every hundredths value in sequence, then R3 carries with continuous ticks
        for (int i = 0; i < 150; i++) cyc(1'b1, "R1");
        for (int i = 0; i < 6900; i++) cyc(1'b1, "R3");
        // R1: idle cycles leave the word alone
        for (int i = 0; i < 40; i++) cyc(1'b0, "R1 idle");
        // R2: sparse ticks, one in three cycles
        for (int i = 0; i < 900; i++) cyc((i % 3) == 0, "R2");

        // R7 clear held across ticks, then released
        set_adj(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) cyc(1'b1, "R7");
        set_adj(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 250; i++) cyc(1'b1, "R7 after");

        // R8 minute stepping across a minute wrap
        set_adj(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6200; i++) cyc(1'b1, "R8");
        set_adj(1'b0, 1'b0, 1'b0);

        // R9 hour stepping across the 23 wrap
        set_adj(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 2600; i++) cyc(1'b1, "R9");

        // R4 drive to 23:59 and let the natural carry reach midnight
        guard = 0;
        while (m_hh != 23 && guard < 3000) begin cyc(1'b1, "R9 to 23"); guard++; end
        set_adj(1'b0, 1'b1, 1'b0);
        guard = 0;
        while (m_mm != 59 && guard < 7000) begin cyc(1'b1, "R8 to 59"); guard++; end
        set_adj(1'b0, 1'b0, 1'b0);
        chk("R4 setup", {24'd0, time_bcd_o[31:24]}, 32'h23);
        guard = 0;
        while (m_hh != 0 && guard < 7000) begin cyc(1'b1, "R4"); guard++; end
        chk("R4 midnight", time_bcd_o, 32'h0000_0000);

        // R5 field positions with a known pattern
        for (int i = 0; i < 1234; i++) cyc(1'b1, "R5 run");
        chk("R5 hours", {24'd0, time_bcd_o[31:24]}, {24'd0, bcd2(m_hh)});
        chk("R5 minutes", {24'd0, time_bcd_o[23:16]}, {24'd0, bcd2(m_mm)});
        chk("R5 seconds", {24'd0, time_bcd_o[15:8]}, 32'h12);
        chk("R5 hundredths", {24'd0, time_bcd_o[7:0]}, 32'h34);

        // R6 reset in the middle of a run
        do_reset("R6 mid");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule